// File: doc/BRIEF.md
# Cold and Warm Reset Bring-Up Sequencer

This block sits at the root of a multi-domain chip's reset tree. It separates a power-on (cold) reset from a reset-pin (warm) reset and then walks the chip through an ordered bring-up. Each bring-up step gets a one-cycle start pulse and is finished by a done pulse from the subsystem that owns it. Five steps use handshakes: clock-generator calibration (step 0), I/O link training (step 1), power-plane enable (step 2), fabric and lookup-table initialisation (step 3) and boot fetch (step 4). The first four make up the uncore bring-up.

After the uncore steps finish, the sequencer switches core power on, then releases core reset, then starts the boot fetch. The boot fetch is sent to the local platform hub or across the inter-socket link, as the strap says. A warm reset runs the same sequence but skips the cold-only steps 0 and 2. It also never pulses the sticky-domain reset, so error logs and machine-check records survive it.

A step that does not answer within a programmable number of cycles parks the sequencer in a fault state. Loss of power-good sends the sequencer back to cold idle at once.

Top module: `rst_seq_top`

## Requirements
- R1: After a cold reset, the start pulses come in the order step 0, 1, 2, 3, then 4, and each one follows the done pulse of the step before it.
- R2: After a warm reset, which is the reset pin going low and then high while power-good stays high, only steps 1, 3 and 4 are started, in that order.
- R3: `sticky_rst_o` is high from the loss of power-good until the cold flow starts its first step. It is never high during or after a warm reset.
- R4: `core_pwr_en_o` rises only in the cycle after step 3's done is accepted. `core_rst_n_o` is high only while `core_pwr_en_o` is high, and step 4 starts only after the core reset is released.
- R5: `boot_sel_o` takes the value of `strap_i` in the cycle the sequencer leaves idle (0 = local hub, 1 = inter-socket link). Later changes on `strap_i` do not affect it.
- R6: Each start pulse lasts one cycle, and only one step is started at a time.
- R7: If the step being waited on gives no done within `tmo_limit_i` cycles, `fault_o` goes to 1. Core power and core reset release are then dropped, and no further step is started.
- R8: While `pwr_good_i` is low, every output is at its reset value, and it gets there without waiting for a clock edge. The reset values are: no start pulse, core power 0, core reset low, fault 0, sticky reset 1, warm flag 0.
- R9: If the reset pin goes low in the middle of a sequence, core power and core reset release are removed. When the pin is released, the warm flow starts again.
- R10: `warm_flag_o` is 0 after a cold reset and 1 after a warm reset.
- R11: A done pulse on any step other than the one being waited on is ignored.
- R12: A warm reset clears a fault, and the next warm flow completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| pwr_good_i | input | 1 | Power-good; low clears everything asynchronously |
| rst_pin_n_i | input | 1 | Active-low platform reset pin |
| strap_i | input | 1 | Boot-source strap |
| tmo_limit_i | input | TMO_W | Per-step timeout in cycles |
| step_done_i | input | 5 | Per-step done pulses |
| step_start_o | output | 5 | Per-step start pulses |
| sticky_rst_o | output | 1 | Sticky-domain reset, active high |
| core_pwr_en_o | output | 1 | Core power enable |
| core_rst_n_o | output | 1 | Core reset, active low |
| boot_sel_o | output | 1 | Boot source: 0 local hub, 1 inter-socket link |
| fault_o | output | 1 | Step timeout fault |
| warm_flag_o | output | 1 | Reset type: 0 cold, 1 warm |

## Verification
The bench aims at the cold-only steps and the sticky reset on a warm reset. A design that mixed up the two flavours would start step 0 or 2, or pulse the sticky reset, and destroy the error logs. It also drops the reset pin in the middle of a boot wait and removes power-good in the middle of a flow. A design with a weak abort path would leave core power on or keep its old state. Stray done pulses on steps that are not being waited on check that the sequence cannot skip ahead. A step that never answers must produce a fault rather than a hang, and a strap that changes after release must not move the boot target.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int N_STEP = 5;
  localparam int IDX_W  = $clog2(N_STEP);
  typedef logic [IDX_W-1:0] step_idx_t;

  localparam step_idx_t STEP_FABRIC = step_idx_t'(3);
  localparam step_idx_t STEP_BOOT   = step_idx_t'(4);
  // steps that only a power-on reset runs: clock calibration and power planes
  localparam logic [N_STEP-1:0] COLD_ONLY = 5'b00101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_RUN, ST_PWRON, ST_RELEASE, ST_DONE, ST_FAULT
  } seq_state_t;

  // first applicable uncore step at or after 'from'; STEP_BOOT when none left
  function automatic step_idx_t pick_step(input step_idx_t from, input logic cold);
    step_idx_t r;
    logic hit;
    r   = STEP_BOOT;
    hit = 1'b0;
    for (int j = 0; j < int'(STEP_BOOT); j++) begin
      if (!hit && j >= int'(from) && (cold || !COLD_ONLY[j])) begin
        r   = step_idx_t'(j);
        hit = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sh_q <= '0;
    else           sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = clr_i || (run_i && (cnt_q != {W{1'b1}}));

  always_comb begin
    cnt_d = cnt_q + W'(1);
    if (clr_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              pwr_good_i,
  input  logic              rst_pin_n_i,
  input  logic              strap_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic [N_STEP-1:0] step_done_i,
  output logic [N_STEP-1:0] step_start_o,
  output logic              sticky_rst_o,
  output logic              core_pwr_en_o,
  output logic              core_rst_n_o,
  output logic              boot_sel_o,
  output logic              fault_o,
  output logic              warm_flag_o
);
  logic pg_ok, pin_ok, tmo_hit, wait_run;

  // power-good drives the asynchronous clear, released after the sync stages
  rst_seq_sync #(.STAGES(SYNC_STAGES)) pg_sync_i (
    .clk_i(clk_i), .arst_n_i(pwr_good_i), .d_i(1'b1), .q_o(pg_ok));

  rst_seq_sync #(.STAGES(SYNC_STAGES)) pin_sync_i (
    .clk_i(clk_i), .arst_n_i(pwr_good_i), .d_i(rst_pin_n_i), .q_o(pin_ok));

  seq_state_t state_q, state_d;
  step_idx_t  cur_q, cur_d, nxt_step;
  logic       strobe_q, strobe_d;
  logic       cold_q, cold_d;
  logic       strap_q, strap_d;
  logic       pwr_q, pwr_d;
  logic       rel_q, rel_d;

  assign wait_run = (state_q == ST_RUN) && !strobe_q;
  assign nxt_step = pick_step(cur_q + step_idx_t'(1), cold_q);

  rst_seq_timer #(.W(TMO_W)) tmr_i (
    .clk_i(clk_i), .rst_n_i(pg_ok), .clr_i(strobe_q), .run_i(wait_run),
    .limit_i(tmo_limit_i), .expired_o(tmo_hit));

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    strobe_d = 1'b0;
    cold_d   = cold_q;
    strap_d  = strap_q;
    pwr_d    = pwr_q;
    rel_d    = rel_q;
    if (!pin_ok && state_q != ST_IDLE && state_q != ST_HOLD) begin
      // reset pin mid-flow: abort, the rerun is a warm one
      state_d = ST_HOLD;
      cold_d  = 1'b0;
      pwr_d   = 1'b0;
      rel_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_HOLD: begin
          if (pin_ok) begin
            strap_d  = strap_i;
            cur_d    = pick_step(step_idx_t'(0), cold_q);
            strobe_d = 1'b1;
            state_d  = ST_RUN;
          end
        end
        ST_RUN: begin
          if (tmo_hit) begin
            state_d = ST_FAULT;
            pwr_d   = 1'b0;
            rel_d   = 1'b0;
          end else if (!strobe_q && step_done_i[cur_q]) begin
            if (cur_q == STEP_BOOT) begin
              state_d = ST_DONE;
            end else if (nxt_step == STEP_BOOT) begin
              state_d = ST_PWRON;
              pwr_d   = 1'b1;
            end else begin
              cur_d    = nxt_step;
              strobe_d = 1'b1;
            end
          end
        end
        ST_PWRON: begin
          state_d = ST_RELEASE;
          rel_d   = 1'b1;
        end
        ST_RELEASE: begin
          state_d  = ST_RUN;
          cur_d    = STEP_BOOT;
          strobe_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge pg_ok) begin
    if (!pg_ok) begin
      state_q  <= ST_IDLE;
      cur_q    <= '0;
      strobe_q <= 1'b0;
      cold_q   <= 1'b1;
      strap_q  <= 1'b0;
      pwr_q    <= 1'b0;
      rel_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      strobe_q <= strobe_d;
      cold_q   <= cold_d;
      strap_q  <= strap_d;
      pwr_q    <= pwr_d;
      rel_q    <= rel_d;
    end
  end

  assign step_start_o  = strobe_q ? ({{(N_STEP-1){1'b0}}, 1'b1} << cur_q) : '0;
  assign sticky_rst_o  = (state_q == ST_IDLE);
  assign core_pwr_en_o = pwr_q;
  assign core_rst_n_o  = rel_q;
  assign boot_sel_o    = strap_q;
  assign fault_o       = (state_q == ST_FAULT);
  assign warm_flag_o   = !cold_q;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk
  import rst_seq_pkg::*;
(
  input logic              clk_i,
  input logic              pwr_good_i,
  input logic [N_STEP-1:0] step_done_i,
  input logic [N_STEP-1:0] step_start_o,
  input logic              sticky_rst_o,
  input logic              core_pwr_en_o,
  input logic              core_rst_n_o,
  input logic              boot_sel_o,
  input logic              fault_o,
  input logic              warm_flag_o
);
  AST_PWR_AFTER_FABRIC: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    $rose(core_pwr_en_o) |-> $past(step_done_i[STEP_FABRIC])); // R4
  AST_REL_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    core_rst_n_o |-> core_pwr_en_o); // R4
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (step_start_o != '0) |=> (step_start_o == '0)); // R6
  AST_WARM_KEEPS_STICKY: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    warm_flag_o |-> !sticky_rst_o); // R3
  AST_BOOT_SEL_HELD: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (core_rst_n_o && $past(core_rst_n_o)) |-> $stable(boot_sel_o)); // R5
  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    fault_o |-> (!core_pwr_en_o && !core_rst_n_o && step_start_o == '0)); // R7
endmodule

bind rst_seq_top rst_seq_chk chk_i (.*);

// File: tb/rst_seq_top_tb.sv
module rst_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RESP_DLY   = 3;
  localparam int NS         = 5;

  logic            clk = 1'b0;
  logic            pwr_good, rst_pin_n, strap;
  logic [15:0]     tmo_limit;
  logic [NS-1:0]   step_done, step_start, rdone, stray, mute;
  logic            sticky, core_pwr, core_rel, boot_sel, fault, warm_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign step_done = rdone | stray;

  rst_seq_top dut_i (
    .clk_i(clk), .pwr_good_i(pwr_good), .rst_pin_n_i(rst_pin_n), .strap_i(strap),
    .tmo_limit_i(tmo_limit), .step_done_i(step_done), .step_start_o(step_start),
    .sticky_rst_o(sticky), .core_pwr_en_o(core_pwr), .core_rst_n_o(core_rel),
    .boot_sel_o(boot_sel), .fault_o(fault), .warm_flag_o(warm_flag));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stub responders and flow monitor
  int          cnt [NS];
  logic [NS-1:0] mask;
  int          last_idx;
  bit          order_ok, sticky_seen, order_bad, fab_seen;

  task automatic clear_log();
    mask        = '0;
    last_idx    = -1;
    order_ok    = 1'b1;
    sticky_seen = 1'b0;
    order_bad   = 1'b0;
    fab_seen    = 1'b0;
  endtask

  initial begin
    rdone = '0;
    for (int i = 0; i < NS; i++) cnt[i] = 0;
  end

  always @(negedge clk) begin
    rdone = '0;
    for (int i = 0; i < NS; i++) begin
      if (step_start[i]) begin
        mask[i] = 1'b1;
        if (i <= last_idx) order_ok = 1'b0;
        last_idx = i;
        cnt[i] = mute[i] ? 0 : RESP_DLY;
      end else if (cnt[i] > 0) begin
        cnt[i]--;
        if (cnt[i] == 0) rdone[i] = 1'b1;
      end
    end
    if (rdone[3]) fab_seen = 1'b1;
    if (core_pwr && !fab_seen) order_bad = 1'b1;
    if (core_rel && !core_pwr) order_bad = 1'b1;
    if (sticky) sticky_seen = 1'b1;
  end

  task automatic start_cold(input logic s);
    pwr_good  = 1'b0;
    rst_pin_n = 1'b0;
    #(3*CLK_PERIOD);
    @(negedge clk);
    clear_log();
    pwr_good = 1'b1;
    repeat (6) @(negedge clk);
    strap     = s;
    rst_pin_n = 1'b1;
  endtask

  task automatic start_warm(input logic s);
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (5) @(negedge clk);
    clear_log();
    strap     = s;
    rst_pin_n = 1'b1;
  endtask

  typedef struct packed {
    bit          warm;
    bit          strap;
    bit [NS-1:0] exp_mask;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{warm: 1'b0, strap: 1'b0, exp_mask: 5'b11111},
    '{warm: 1'b1, strap: 1'b1, exp_mask: 5'b11010},
    '{warm: 1'b0, strap: 1'b1, exp_mask: 5'b11111},
    '{warm: 1'b1, strap: 1'b0, exp_mask: 5'b11010}
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000*CLK_PERIOD);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    pwr_good  = 1'b0;
    rst_pin_n = 1'b0;
    strap     = 1'b0;
    tmo_limit = 16'd40;
    stray     = '0;
    mute      = '0;
    clear_log();
    #(2*CLK_PERIOD + 1);

    // R8: reset state while power-good is low
    chk(step_start == '0 && !core_pwr && !core_rel && !fault, "R8 outputs idle", int'(core_pwr), 0);
    chk(sticky == 1'b1 && warm_flag == 1'b0, "R8 sticky/flag", int'(sticky), 1);

    // vector table: cold and warm flows with both strap values
    foreach (VECS[v]) begin
      if (VECS[v].warm) start_warm(VECS[v].strap);
      else              start_cold(VECS[v].strap);
      repeat (15) @(negedge clk);
      strap = ~VECS[v].strap;  // R5: late strap change must not matter
      repeat (120) @(negedge clk);
      chk(mask == VECS[v].exp_mask, VECS[v].warm ? "R2 warm steps" : "R1 cold steps",
          int'(mask), int'(VECS[v].exp_mask));
      chk(order_ok, "R1 step order", int'(order_ok), 1);
      chk(!order_bad, "R4 power/release order", int'(order_bad), 0);
      chk(core_pwr && core_rel && !fault, "R4 core up", int'({core_pwr, core_rel}), 3);
      chk(boot_sel == VECS[v].strap, "R5 boot select", int'(boot_sel), int'(VECS[v].strap));
      chk(warm_flag == VECS[v].warm, "R10 reset type", int'(warm_flag), int'(VECS[v].warm));
      chk(sticky_seen == !VECS[v].warm, "R3 sticky reset", int'(sticky_seen), int'(!VECS[v].warm));
      chk(!sticky, "R3 sticky released", int'(sticky), 0);
    end

    // R11: stray done pulses on steps not being waited on
    start_warm(1'b0);
    repeat (4) @(negedge clk);
    stray = 5'b11000;
    @(negedge clk);
    stray = '0;
    repeat (2) @(negedge clk);
    chk(mask[4] == 1'b0 && !core_pwr, "R11 stray done ignored", int'(mask), 2);
    repeat (100) @(negedge clk);
    chk(mask == 5'b11010 && order_ok, "R11 flow intact", int'(mask), 26);

    // R7: step 3 never answers
    tmo_limit = 16'd20;
    mute      = 5'b01000;
    start_warm(1'b0);
    repeat (100) @(negedge clk);
    chk(fault == 1'b1, "R7 timeout fault", int'(fault), 1);
    chk(!core_pwr && !core_rel && mask[4] == 1'b0, "R7 quiet after fault", int'(mask), 10);

    // R12: warm reset recovers from the fault
    mute = '0;
    start_warm(1'b1);
    repeat (120) @(negedge clk);
    chk(!fault && core_rel && mask == 5'b11010, "R12 recovery", int'(mask), 26);

    // R9: reset pin in the middle of the boot wait
    tmo_limit = 16'd1000;
    mute      = 5'b10000;
    start_warm(1'b0);
    repeat (60) @(negedge clk);
    chk(core_pwr && core_rel, "R9 waiting in boot", int'({core_pwr, core_rel}), 3);
    rst_pin_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!core_pwr && !core_rel, "R9 abort drops core", int'({core_pwr, core_rel}), 0);
    mute = '0;
    clear_log();
    rst_pin_n = 1'b1;
    repeat (120) @(negedge clk);
    chk(mask == 5'b11010 && warm_flag && core_rel, "R9 warm rerun", int'(mask), 26);

    // R8: power-good lost mid-flow clears outputs without a clock edge
    start_cold(1'b1);
    repeat (25) @(negedge clk);
    #1;
    pwr_good = 1'b0;
    #1;
    chk(!core_pwr && !core_rel && step_start == '0 && sticky && !warm_flag,
        "R8 async clear", int'({core_pwr, core_rel, sticky}), 1);
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule